// File: doc/BRIEF.md
# Two-Level Dynamic Branch Direction Predictor

This block guesses, for each fetch address of a pipelined 32-bit core, whether a conditional branch at that address will be taken. The fetch stage presents a PC on the lookup port. One clock later the block returns a single taken/not-taken bit.

When a branch resolves later in the pipeline, the core presents the branch PC, the real outcome and a valid strobe on the update port. The block then trains its state. All state is a table of 2-bit saturating counters. In the history-based organisations there are also shift registers that record recent outcomes.

The organisation is picked at elaboration time by a mode parameter, with three choices:

- **Bimodal:** the counters are addressed by PC bits only.
- **Gshare:** the PC bits are XOR-folded with one global outcome history that all branches share.
- **Local:** each branch slot keeps its own outcome history, and that history alone addresses a counter table shared by all slots.

Top module: `bp_predictor`

## Requirements
- R1: After synchronous reset every counter holds 01 (weak not-taken), every history register holds zero, and `lk_taken` is 0. A single taken update to a fresh entry is therefore enough to make it predict taken.
- R2: The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. The prediction is the counter's MSB.
- R3: An accepted update adds one to the selected counter on a taken outcome and subtracts one on a not-taken outcome. The counter holds at 11 and at 00, so one contrary outcome after saturation does not flip the prediction.
- R4: With `MODE` = 0 (bimodal) the counter index is PC[HIST_W+1:2]. PC bits [1:0] and bits above HIST_W+1 do not affect the index, so PCs that differ only there share a counter.
- R5: With `MODE` = 1 (gshare) the counter index is PC[HIST_W+1:2] XOR the global history. Each accepted update shifts that history one place left and puts the real outcome (1 = taken) into bit 0.
- R6: With `MODE` = 2 (local) a history table of 2^LHT_W entries is addressed by PC[LHT_W+1:2]. The selected entry addresses a shared table of 2^HIST_W counters. An accepted update shifts the outcome into that branch's own entry only.
- R7: `lk_taken` is registered. It reflects the `lk_pc` that was present at the previous rising clock edge.
- R8: When a lookup and an update hit the same state in the same cycle, the lookup returns the prediction from before that update.
- R9: While `up_valid` is 0, `up_pc` and `up_taken` change no counter and no history.
- R10: The three organisations share one port list. The `MODE` parameter alone selects among them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Registered prediction for the previous cycle's `lk_pc` |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
A counter that steps wrongly, or a reset value that is wrong, shows up at the first lookup that reaches the entry. That lookup's result is visible one clock after the address is presented. A lost or misordered history bit behaves differently: no lone lookup exposes it. It shows only as a wrong index, as a prediction that disagrees with an independent model of all three organisations. That can happen many updates later, once the corrupted pattern meets an entry whose counter differs. Directed patterns therefore drive saturation, aliasing and same-cycle hazards quickly, while long random runs with a small PC pool are needed to make history faults reach the port.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    BP_BIMODAL = 2'd0,
    BP_GSHARE  = 2'd1,
    BP_LOCAL   = 2'd2
  } bp_mode_e;

  typedef logic [1:0] bp_ctr_t;

  localparam bp_ctr_t CTR_WEAK_NT = 2'b01;

  // saturating step of a direction counter
  function automatic bp_ctr_t ctr_step(input bp_ctr_t cur, input logic taken);
    bp_ctr_t nxt;
    if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'd1;
    else       nxt = (cur == 2'b00) ? cur : cur - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bp_history.sv
module bp_history #(
  parameter bp_pkg::bp_mode_e MODE = bp_pkg::BP_GSHARE,
  parameter int HIST_W = 8,
  parameter int LHT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LHT_W-1:0]  lk_slot,
  input  logic [LHT_W-1:0]  up_slot,
  input  logic              up_valid,
  input  logic              up_taken,
  output logic [HIST_W-1:0] lk_hist,
  output logic [HIST_W-1:0] up_hist
);
  localparam int LHT_DEPTH = 1 << LHT_W;

  generate
    if (MODE == bp_pkg::BP_GSHARE) begin : g_global
      logic [HIST_W-1:0] ghr_q;
      logic              unused_slots;
      assign unused_slots = ^{lk_slot, up_slot};

      always_ff @(posedge clk) begin
        if (rst)           ghr_q <= '0;
        else if (up_valid) ghr_q <= {ghr_q[HIST_W-2:0], up_taken};
      end
      assign lk_hist = ghr_q;
      assign up_hist = ghr_q;
    end else if (MODE == bp_pkg::BP_LOCAL) begin : g_local
      logic [HIST_W-1:0] lht [LHT_DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < LHT_DEPTH; i++) lht[i] <= '0;
        end else if (up_valid) begin
          lht[up_slot] <= {lht[up_slot][HIST_W-2:0], up_taken};
        end
      end
      assign lk_hist = lht[lk_slot];
      assign up_hist = lht[up_slot];
    end else begin : g_none
      logic unused_hist_in;
      assign unused_hist_in = ^{clk, rst, lk_slot, up_slot, up_valid, up_taken};
      assign lk_hist = '0;
      assign up_hist = '0;
    end
  endgenerate

endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter bp_pkg::bp_mode_e MODE = bp_pkg::BP_GSHARE,
  parameter int HIST_W = 8
) (
  input  logic [HIST_W-1:0] pc_bits,
  input  logic [HIST_W-1:0] hist,
  output logic [HIST_W-1:0] idx
);
  logic unused_idx_in;
  assign unused_idx_in = ^{pc_bits, hist};

  generate
    if (MODE == bp_pkg::BP_GSHARE) begin : g_xor
      assign idx = pc_bits ^ hist;
    end else if (MODE == bp_pkg::BP_LOCAL) begin : g_hist
      assign idx = hist;
    end else begin : g_pc
      assign idx = pc_bits;
    end
  endgenerate

endmodule

// File: rtl/bp_pht.sv
module bp_pht #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  bp_pkg::bp_ctr_t tbl [DEPTH];

  // read samples the old contents, so a colliding write is not seen
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_taken <= 1'b0;
      for (int i = 0; i < DEPTH; i++) tbl[i] <= bp_pkg::CTR_WEAK_NT;
    end else begin
      rd_taken <= tbl[rd_idx][1];
      if (wr_en) tbl[wr_idx] <= bp_pkg::ctr_step(tbl[wr_idx], wr_taken);
    end
  end

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor #(
  parameter bp_pkg::bp_mode_e MODE = bp_pkg::BP_GSHARE,
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter int LHT_W  = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  logic [HIST_W-1:0] lk_hist, up_hist;
  logic [HIST_W-1:0] lk_idx, up_idx;
  logic              unused_pc;

  assign unused_pc = ^{lk_pc, up_pc};

  bp_history #(.MODE(MODE), .HIST_W(HIST_W), .LHT_W(LHT_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .lk_slot  (lk_pc[LHT_W+1:2]),
    .up_slot  (up_pc[LHT_W+1:2]),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .lk_hist  (lk_hist),
    .up_hist  (up_hist)
  );

  bp_index #(.MODE(MODE), .HIST_W(HIST_W)) u_lk_idx (
    .pc_bits (lk_pc[HIST_W+1:2]),
    .hist    (lk_hist),
    .idx     (lk_idx)
  );

  bp_index #(.MODE(MODE), .HIST_W(HIST_W)) u_up_idx (
    .pc_bits (up_pc[HIST_W+1:2]),
    .hist    (up_hist),
    .idx     (up_idx)
  );

  bp_pht #(.IDX_W(HIST_W)) u_pht (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (lk_idx),
    .rd_taken (lk_taken),
    .wr_en    (up_valid),
    .wr_idx   (up_idx),
    .wr_taken (up_taken)
  );

endmodule

// File: rtl/bp_predictor_chk.sv
module bp_predictor_chk #(
  parameter bp_pkg::bp_mode_e MODE = bp_pkg::BP_GSHARE,
  parameter int PC_W   = 32,
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   lk_pc,
  input logic              lk_taken,
  input logic              up_valid,
  input logic [PC_W-1:0]   up_pc,
  input logic              up_taken,
  input logic [HIST_W-1:0] up_hist
);

  p_reset_not_taken_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_taken);

  generate
    if (MODE == bp_pkg::BP_GSHARE) begin : g_gs
      p_ghr_shift_r5: assert property (@(posedge clk) disable iff (rst)
        up_valid |=> up_hist == {$past(up_hist[HIST_W-2:0]), $past(up_taken)});
      p_ghr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !up_valid |=> $stable(up_hist));
    end
    if (MODE == bp_pkg::BP_BIMODAL) begin : g_bim
      // two taken steps from any state reach 10 or 11
      p_two_taken_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(up_valid && up_taken, 2) && $past(up_valid && up_taken) &&
         $past(up_pc, 2) == $past(up_pc) && lk_pc == $past(up_pc)) |=> lk_taken);
      p_two_not_taken_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(up_valid && !up_taken, 2) && $past(up_valid && !up_taken) &&
         $past(up_pc, 2) == $past(up_pc) && lk_pc == $past(up_pc)) |=> !lk_taken);
    end
  endgenerate

endmodule

bind bp_predictor bp_predictor_chk #(.MODE(MODE), .PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_pc    (lk_pc),
  .lk_taken (lk_taken),
  .up_valid (up_valid),
  .up_pc    (up_pc),
  .up_taken (up_taken),
  .up_hist  (up_hist)
);

// File: tb/bp_predictor_bench.sv
module bp_predictor_bench;
  localparam int HW = 8;
  localparam int LW = 6;
  localparam int D  = 1 << HW;
  localparam int LD = 1 << LW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lk_pc = '0;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic        up_taken = 1'b0;
  logic        gs_taken, bim_taken, loc_taken;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  bp_predictor #(.MODE(bp_pkg::BP_GSHARE), .HIST_W(HW), .LHT_W(LW)) u_bp_predictor (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(gs_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));
  bp_predictor #(.MODE(bp_pkg::BP_BIMODAL), .HIST_W(HW), .LHT_W(LW)) u_bp_predictor_bim (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(bim_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));
  bp_predictor #(.MODE(bp_pkg::BP_LOCAL), .HIST_W(HW), .LHT_W(LW)) u_bp_predictor_loc (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(loc_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  // independent reference state
  logic [1:0]    m_bim [D];
  logic [1:0]    m_gs  [D];
  logic [1:0]    m_lc  [D];
  logic [HW-1:0] m_ghr;
  logic [HW-1:0] m_lht [LD];

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < D; i++) begin
      m_bim[i] = 2'b01; m_gs[i] = 2'b01; m_lc[i] = 2'b01;
    end
    for (int i = 0; i < LD; i++) m_lht[i] = '0;
    m_ghr = '0;
  endtask

  task automatic check(input string tag, input string mode, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s mode=%s pc=%h got %0b expected %0b", tag, mode, lk_pc, act, exp);
    end
  endtask

  // drive one cycle, advance model, compare one cycle later (R7 latency)
  task automatic step(input logic [31:0] lpc, input logic uv, input logic [31:0] upc,
                      input logic ut, input string tag);
    logic eb, eg, el;
    logic [HW-1:0] ix;
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
    eb = m_bim[lpc[HW+1:2]][1];
    eg = m_gs[lpc[HW+1:2] ^ m_ghr][1];
    el = m_lc[m_lht[lpc[LW+1:2]]][1];
    if (uv) begin
      m_bim[upc[HW+1:2]] = sat(m_bim[upc[HW+1:2]], ut);
      ix = upc[HW+1:2] ^ m_ghr;
      m_gs[ix] = sat(m_gs[ix], ut);
      m_ghr = {m_ghr[HW-2:0], ut};
      ix = m_lht[upc[LW+1:2]];
      m_lc[ix] = sat(m_lc[ix], ut);
      m_lht[upc[LW+1:2]] = {m_lht[upc[LW+1:2]][HW-2:0], ut};
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "bimodal", bim_taken, eb);
    check(tag, "gshare", gs_taken, eg);
    check(tag, "local", loc_taken, el);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] pool [8];
    int unsigned seed_v;
    seed_v = $urandom(32'h1badcafe);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state is not-taken everywhere
    check("R1", "bimodal", bim_taken, 1'b0);
    check("R1", "gshare", gs_taken, 1'b0);
    check("R1", "local", loc_taken, 1'b0);
    step(32'h100, 1'b0, 32'h0, 1'b0, "R1");
    step(32'h2f4, 1'b0, 32'h0, 1'b0, "R1");
    // R8: same-cycle update and lookup see old value, then R1 weak start
    step(32'h100, 1'b1, 32'h100, 1'b1, "R8");
    step(32'h100, 1'b0, 32'h0, 1'b0, "R1");
    // R2/R3: saturate up, one contrary outcome
    for (int i = 0; i < 4; i++) step(32'h200, 1'b1, 32'h200, 1'b1, "R3");
    step(32'h200, 1'b1, 32'h200, 1'b0, "R3");
    step(32'h200, 1'b0, 32'h0, 1'b0, "R2");
    for (int i = 0; i < 5; i++) step(32'h200, 1'b1, 32'h200, 1'b0, "R3");
    step(32'h200, 1'b1, 32'h200, 1'b1, "R3");
    step(32'h200, 1'b0, 32'h0, 1'b0, "R3");
    // R4: aliasing through ignored PC bits
    step(32'h300, 1'b1, 32'h300, 1'b1, "R4");
    step(32'h300, 1'b1, 32'h300, 1'b1, "R4");
    step(32'h300 + (32'h1 << (HW + 2)), 1'b0, 32'h0, 1'b0, "R4");
    step(32'h303, 1'b0, 32'h0, 1'b0, "R4");
    // R9: updates without strobe are ignored
    for (int i = 0; i < 20; i++)
      step(32'h300, 1'b0, $urandom, 1'(i), "R9");
    // R7: alternating lookups of trained pcs
    for (int i = 0; i < 3; i++) step(32'h40, 1'b1, 32'h44, 1'b1, "R7");
    for (int i = 0; i < 3; i++) step(32'h48, 1'b1, 32'h4c, 1'b0, "R7");
    for (int i = 0; i < 6; i++) step((i % 2) ? 32'h4c : 32'h44, 1'b0, 32'h0, 1'b0, "R7");
    // R5/R6: repeating pattern on one branch
    for (int i = 0; i < 60; i++) step(32'h500, 1'b1, 32'h500, (i % 3) != 2, "R6");
    for (int i = 0; i < 60; i++) step(32'h600 + 32'((i % 2) * 4), 1'b1,
                                      32'h600 + 32'((i % 2) * 4), (i % 4) < 2, "R5");
    // R10: random mix over a small pc pool
    for (int i = 0; i < 8; i++) pool[i] = {$urandom} & 32'hffff_fffc;
    for (int i = 0; i < 4000; i++)
      step(pool[$urandom % 8] | ($urandom % 4), ($urandom % 10) < 7,
           pool[$urandom % 8], ($urandom % 3) != 0, "R10");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule